// File: doc/BRIEF.md
# Buzzer Tone Generator with Stepped Envelope

This block produces a square-wave buzzer signal from a 32.768 kHz reference clock. One reference cycle is one `clk` cycle. A 3-bit tone code picks one of eight periods, and a 3-bit loudness code picks the share of each period that the output spends active. Loudness is set by duty ratio only: a lower level gives a narrower pulse.

The output is driven in one of two ways. In continuous mode it runs for as long as `cont_en` is held. In burst mode a trigger pulse produces one burst whose start is aligned to a 256 Hz tick. An optional envelope takes over the loudness code and steps it from the loudest level to the softest at one of two rates. A polarity input inverts the pin, including its idle level.

Output control is a four-state machine:

| State | Meaning |
|---|---|
| `ST_IDLE` | The pin is at its idle level. |
| `ST_CONT` | Continuous tone. |
| `ST_WAIT` | A burst is armed and waits for the next 256 Hz tick. |
| `ST_RUN` | The burst tone is running. |

The transitions are:

- **IDLE to CONT:** `cont_en` is high.
- **IDLE to WAIT:** a trigger arrives while `cont_en` is low.
- **CONT to IDLE:** `cont_en` drops.
- **WAIT to RUN:** a 256 Hz tick occurs.
- **WAIT or RUN to CONT:** `cont_en` rises.
- **WAIT or RUN to IDLE:** a stop pulse arrives.
- **RUN to IDLE:** the burst's tick count is used up.

Top module: `buzz_gen`

## Requirements
- R1: While the tone runs, the output period in clock cycles is N = 8, 10, 12, 14 for `tone_sel` 0 to 3, and N = 16, 20, 24, 28 for `tone_sel` 4 to 7.
- R2: In every N consecutive cycles of a running tone, the output is active for H = N/2 − L cycles, where L is the loudness level 0 to 7. When N/2 ≤ L, H is 1 instead. Level 0 (code 000) is therefore the loudest, at 50 %, and level 7 the softest.
- R3: With `env_on`=1, `level_sel` is ignored. The level advances by one every 2048 cycles when `env_slow`=0, or every 4096 cycles when `env_slow`=1, and holds at 7 once it gets there.
- R4: A pulse on `env_restart` returns the envelope level to 0 and restarts its step timer.
- R5: A pulse on `shot_go` while `cont_en`=0 sets `shot_busy` at the next cycle. The tone then starts at the next 256 Hz tick (every 128 cycles) and runs for exactly 8 ticks when `shot_long`=0 or 32 ticks when `shot_long`=1. After that, `shot_busy` clears.
- R6: A `shot_go` pulse while continuous output is on has no effect: `shot_busy` stays 0, and no burst follows once `cont_en` drops.
- R7: A pulse on `shot_halt` during a burst clears `shot_busy` and returns the pin to idle at the next cycle.
- R8: With `pol_neg`=0 the pin idles low and the tone's active phase is high. With `pol_neg`=1 both are inverted.
- R9: After reset, `shot_busy` is 0 and the pin sits at its idle level.
- R10: The tone begins in its active phase in the cycle after `cont_en` rises, and the pin returns to idle in the cycle after `cont_en` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tone_sel | input | 3 | Tone period code |
| level_sel | input | 3 | Loudness code, used when the envelope is off |
| env_on | input | 1 | Envelope enable |
| env_restart | input | 1 | Envelope restart pulse |
| env_slow | input | 1 | Envelope step: 0 = 2048 cycles, 1 = 4096 cycles |
| cont_en | input | 1 | Continuous output enable |
| shot_go | input | 1 | Burst trigger pulse |
| shot_long | input | 1 | Burst width: 0 = 8 ticks, 1 = 32 ticks |
| shot_halt | input | 1 | Burst stop pulse |
| pol_neg | input | 1 | Output polarity inversion |
| shot_busy | output | 1 | High while a burst is armed or running |
| bz | output | 1 | Buzzer output pin |

## Verification
A wrong tone phase counter shows up as a wrong period or active count within one tone period, so within 28 cycles at most. A wrong envelope level changes the active count of the very next period, while a wrong step timer shows up as the level changing at the wrong point in a 2048- or 4096-cycle window. A wrong burst state or tick counter shows up at `shot_busy` and at the total number of active output cycles once the burst has ended, so within 4224 cycles. The sweep covers all 64 combinations of tone and loudness code, compares the period and active counts against the formulas, and then runs each control sequence.

// File: rtl/buzz_pkg.sv
package buzz_pkg;
    localparam int SEL_W = 3;
    localparam int PH_W  = 5;

    typedef enum logic [1:0] {ST_IDLE, ST_CONT, ST_WAIT, ST_RUN} buzz_state_e;

    // tone period in reference cycles for a tone code
    function automatic logic [PH_W-1:0] tone_period(input logic [SEL_W-1:0] code);
        logic [PH_W-1:0] base;
        logic [PH_W-1:0] stride;
        base   = code[2] ? PH_W'(16) : PH_W'(8);
        stride = code[2] ? PH_W'(4)  : PH_W'(2);
        return base + stride * PH_W'(code[1:0]);
    endfunction

    // active cycles per period for a loudness level
    function automatic logic [PH_W-1:0] active_len(input logic [PH_W-1:0] period,
                                                   input logic [SEL_W-1:0] lvl);
        logic [PH_W-1:0] half;
        logic [PH_W-1:0] l5;
        half = period >> 1;
        l5   = PH_W'(lvl);
        return (half > l5) ? (half - l5) : PH_W'(1);
    endfunction
endpackage

// File: rtl/buzz_timebase.sv
module buzz_timebase #(
    parameter int DIV = 128
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);

    p_tick_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/buzz_envelope.sv
module buzz_envelope #(
    parameter int STEP_FAST = 2048,
    parameter int STEP_SLOW = 4096
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       env_on,
    input  logic       env_restart,
    input  logic       env_slow,
    output logic [2:0] level
);
    localparam int TW = $clog2(STEP_SLOW);
    localparam logic [TW-1:0] LAST_FAST = TW'(STEP_FAST - 1);
    localparam logic [TW-1:0] LAST_SLOW = TW'(STEP_SLOW - 1);

    logic [TW-1:0] timer;
    logic [TW-1:0] last;

    assign last = env_slow ? LAST_SLOW : LAST_FAST;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            timer <= '0;
            level <= '0;
        end else if (env_restart || !env_on) begin
            timer <= '0;
            level <= '0;
        end else if (timer >= last) begin
            timer <= '0;
            if (level != 3'd7) level <= level + 3'd1;
        end else begin
            timer <= timer + 1'b1;
        end
    end

    p_floor_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (env_on && !env_restart && level == 3'd7) |=> (level == 3'd7));
    p_single_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (env_on && !env_restart) |=> (level == $past(level) || level == $past(level) + 3'd1));
    p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        env_restart |=> (level == 3'd0));
endmodule

// File: rtl/buzz_shot_fsm.sv
module buzz_shot_fsm
    import buzz_pkg::*;
#(
    parameter int TICKS_SHORT = 8,
    parameter int TICKS_LONG  = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic cont_en,
    input  logic shot_go,
    input  logic shot_long,
    input  logic shot_halt,
    output logic tone_on,
    output logic shot_busy
);
    localparam int CW = $clog2(TICKS_LONG + 1);
    localparam logic [CW-1:0] LAST_SHORT = CW'(TICKS_SHORT - 1);
    localparam logic [CW-1:0] LAST_LONG  = CW'(TICKS_LONG - 1);

    buzz_state_e st, st_nx;
    logic [CW-1:0] tcnt;
    logic          long_q;
    logic          run_done;

    assign run_done = tick && (tcnt == (long_q ? LAST_LONG : LAST_SHORT));

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: if (cont_en)        st_nx = ST_CONT;
                     else if (shot_go)   st_nx = ST_WAIT;
            ST_CONT: if (!cont_en)       st_nx = ST_IDLE;
            ST_WAIT: if (cont_en)        st_nx = ST_CONT;
                     else if (shot_halt) st_nx = ST_IDLE;
                     else if (tick)      st_nx = ST_RUN;
            ST_RUN:  if (cont_en)        st_nx = ST_CONT;
                     else if (shot_halt) st_nx = ST_IDLE;
                     else if (run_done)  st_nx = ST_IDLE;
            default:                     st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt   <= '0;
            long_q <= 1'b0;
        end else begin
            if (st == ST_IDLE && !cont_en && shot_go) long_q <= shot_long;
            if (st == ST_WAIT)            tcnt <= '0;
            else if (st == ST_RUN && tick) tcnt <= tcnt + 1'b1;
        end
    end

    always_comb begin
        tone_on   = 1'b0;
        shot_busy = 1'b0;
        unique case (st)
            ST_IDLE: ;
            ST_CONT: tone_on = 1'b1;
            ST_WAIT: shot_busy = 1'b1;
            ST_RUN: begin
                tone_on   = 1'b1;
                shot_busy = 1'b1;
            end
            default: ;
        endcase
    end

    p_ignore_go_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CONT && cont_en) |=> !shot_busy);
    p_halt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (shot_busy && shot_halt && !cont_en) |=> (st == ST_IDLE));
    p_start_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT && tick && !cont_en && !shot_halt) |=> (st == ST_RUN));
    p_no_early_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT && !tick) |=> (st != ST_RUN));
endmodule

// File: rtl/buzz_tone.sv
module buzz_tone
    import buzz_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tone_on,
    input  logic [SEL_W-1:0] tone_sel,
    input  logic [SEL_W-1:0] level,
    input  logic             pol_neg,
    output logic             bz
);
    logic [PH_W-1:0] phase;
    logic [PH_W-1:0] period;
    logic [PH_W-1:0] hi_len;

    assign period = tone_period(tone_sel);
    assign hi_len = active_len(period, level);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         phase <= '0;
        else if (!tone_on)                  phase <= '0;
        else if (phase >= period - 5'd1)    phase <= '0;
        else                                phase <= phase + 5'd1;
    end

    assign bz = tone_on ? ((phase < hi_len) ^ pol_neg) : pol_neg;

    p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tone_on && phase == period - 5'd1) |=> (phase == 5'd0));
    p_start_phase_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tone_on) |-> (phase == 5'd0));
endmodule

// File: rtl/buzz_gen.sv
module buzz_gen
    import buzz_pkg::*;
#(
    parameter int REF_HZ      = 32768,
    parameter int TICKS_SHORT = 8,
    parameter int TICKS_LONG  = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] tone_sel,
    input  logic [2:0] level_sel,
    input  logic       env_on,
    input  logic       env_restart,
    input  logic       env_slow,
    input  logic       cont_en,
    input  logic       shot_go,
    input  logic       shot_long,
    input  logic       shot_halt,
    input  logic       pol_neg,
    output logic       shot_busy,
    output logic       bz
);
    localparam int TICK_DIV  = REF_HZ / 256;
    localparam int STEP_FAST = REF_HZ / 16;
    localparam int STEP_SLOW = REF_HZ / 8;

    logic       tick;
    logic       tone_on;
    logic [2:0] env_level;
    logic [2:0] level_eff;

    buzz_timebase #(.DIV(TICK_DIV)) u_tb (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    buzz_envelope #(.STEP_FAST(STEP_FAST), .STEP_SLOW(STEP_SLOW)) u_env (
        .clk(clk), .rst_n(rst_n), .env_on(env_on), .env_restart(env_restart),
        .env_slow(env_slow), .level(env_level)
    );

    buzz_shot_fsm #(.TICKS_SHORT(TICKS_SHORT), .TICKS_LONG(TICKS_LONG)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cont_en(cont_en),
        .shot_go(shot_go), .shot_long(shot_long), .shot_halt(shot_halt),
        .tone_on(tone_on), .shot_busy(shot_busy)
    );

    assign level_eff = env_on ? env_level : level_sel;

    buzz_tone u_tone (
        .clk(clk), .rst_n(rst_n), .tone_on(tone_on), .tone_sel(tone_sel),
        .level(level_eff), .pol_neg(pol_neg), .bz(bz)
    );

    p_idle_pin_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cont_en && !shot_busy && !$past(cont_en)) |-> (bz == pol_neg));
endmodule

// File: tb/test_buzz_gen.sv
module test_buzz_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] tone_sel = '0;
    logic [2:0] level_sel = '0;
    logic       env_on = 1'b0, env_restart = 1'b0, env_slow = 1'b0;
    logic       cont_en = 1'b0, shot_go = 1'b0, shot_long = 1'b0, shot_halt = 1'b0;
    logic       pol_neg = 1'b0;
    logic       shot_busy, bz;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    buzz_gen i_buzz_gen (
        .clk(clk), .rst_n(rst_n), .tone_sel(tone_sel), .level_sel(level_sel),
        .env_on(env_on), .env_restart(env_restart), .env_slow(env_slow),
        .cont_en(cont_en), .shot_go(shot_go), .shot_long(shot_long),
        .shot_halt(shot_halt), .pol_neg(pol_neg), .shot_busy(shot_busy), .bz(bz)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int per_of(input int code);
        return (code < 4) ? 8 + 2 * code : 16 + 4 * (code - 4);
    endfunction

    function automatic int hi_of(input int n, input int lvl);
        return (n / 2 > lvl) ? n / 2 - lvl : 1;
    endfunction

    task automatic count_high(input int len, output int hi);
        hi = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            hi += int'(bz);
        end
    endtask

    task automatic env_window(input int step, input int k, input int exp_hi, input string req);
        int hi;
        repeat (step / 2) @(negedge clk);
        count_high(28, hi);
        check(req, hi, exp_hi);
        repeat (step / 2 - 28) @(negedge clk);
    endtask

    task automatic run_shot(input bit lng);
        int w, bc, hi, guard;
        w = lng ? 32 : 8;
        shot_long = lng;
        @(negedge clk) shot_go = 1'b1;
        @(negedge clk) shot_go = 1'b0;
        check("R5 busy after go", int'(shot_busy), 1);
        bc = 1; hi = int'(bz); guard = 0;
        while (shot_busy && guard < 10000) begin
            @(negedge clk);
            guard++;
            if (shot_busy) begin
                bc++;
                hi += int'(bz);
            end
        end
        check("R5 active cycles", hi, w * 64);
        check("R5 busy span ok", int'(bc >= w * 128 + 1 && bc <= w * 128 + 128), 1);
        if (!(bc >= w * 128 + 1 && bc <= w * 128 + 128))
            $display("  busy span actual=%0d expected %0d..%0d", bc, w * 128 + 1, w * 128 + 128);
        check("R8 idle after burst", int'(bz), 0);
    endtask

    initial begin
        int hi, hi2, r1, r2, n;
        bit smp [0:127];
        repeat (5) @(negedge clk);
        check("R9 busy at reset", int'(shot_busy), 0);
        check("R9 pin at reset", int'(bz), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 busy after reset", int'(shot_busy), 0);
        pol_neg = 1'b1;
        #1 check("R8 inverted idle", int'(bz), 1);
        @(negedge clk) pol_neg = 1'b0;

        // R1 R2 R10: full sweep of tone and loudness codes
        for (int f = 0; f < 8; f++) begin
            for (int d = 0; d < 8; d++) begin
                n = per_of(f);
                tone_sel = 3'(f); level_sel = 3'(d); cont_en = 1'b1;
                for (int i = 0; i < 3 * n; i++) begin
                    @(negedge clk);
                    smp[i] = bz;
                end
                check("R10 starts active", int'(smp[0]), 1);
                hi = 0; hi2 = 0; r1 = -1; r2 = -1;
                for (int i = 0; i < n; i++) begin
                    hi  += int'(smp[i]);
                    hi2 += int'(smp[i + n]);
                end
                for (int i = 1; i < 3 * n; i++)
                    if (smp[i] && !smp[i-1]) begin
                        if (r1 < 0) r1 = i;
                        else if (r2 < 0) r2 = i;
                    end
                check("R2 active count", hi, hi_of(n, d));
                check("R2 second period", hi2, hi_of(n, d));
                check("R1 period", r2 - r1, n);
                cont_en = 1'b0;
                @(negedge clk);
                check("R10 idle after drop", int'(bz), 0);
            end
        end

        // R8: inverted polarity while running
        tone_sel = 3'd0; level_sel = 3'd2; pol_neg = 1'b1; cont_en = 1'b1;
        count_high(8, hi);
        check("R8 inverted active count", hi, 6);
        cont_en = 1'b0;
        @(negedge clk);
        check("R8 inverted idle after", int'(bz), 1);
        pol_neg = 1'b0;

        // R3 fast envelope, level_sel ignored
        tone_sel = 3'd7; level_sel = 3'd5; cont_en = 1'b1; env_on = 1'b1; env_slow = 1'b0;
        @(negedge clk) env_restart = 1'b1;
        @(negedge clk) env_restart = 1'b0;
        for (int k = 0; k < 9; k++)
            env_window(2048, k, 14 - ((k < 7) ? k : 7), "R3 fast step");
        // R4 restart from the floor
        @(negedge clk) env_restart = 1'b1;
        @(negedge clk) env_restart = 1'b0;
        repeat (100) @(negedge clk);
        count_high(28, hi);
        check("R4 back to level 0", hi, 14);
        // R3 slow rate
        env_slow = 1'b1;
        @(negedge clk) env_restart = 1'b1;
        @(negedge clk) env_restart = 1'b0;
        for (int k = 0; k < 3; k++)
            env_window(4096, k, 14 - k, "R3 slow step");
        cont_en = 1'b0; env_on = 1'b0; env_slow = 1'b0;
        @(negedge clk);

        // R5 bursts
        tone_sel = 3'd0; level_sel = 3'd0;
        run_shot(1'b0);
        run_shot(1'b1);

        // R6: trigger during continuous output
        cont_en = 1'b1;
        @(negedge clk) shot_go = 1'b1;
        @(negedge clk) shot_go = 1'b0;
        check("R6 busy stays low", int'(shot_busy), 0);
        cont_en = 1'b0;
        @(negedge clk);
        check("R6 busy after drop", int'(shot_busy), 0);
        count_high(300, hi);
        check("R6 no late burst", hi, 0);

        // R7: halt mid-burst
        shot_long = 1'b1;
        @(negedge clk) shot_go = 1'b1;
        @(negedge clk) shot_go = 1'b0;
        while (!bz) @(negedge clk);
        repeat (20) @(negedge clk);
        shot_halt = 1'b1;
        @(negedge clk) shot_halt = 1'b0;
        check("R7 busy cleared", int'(shot_busy), 0);
        check("R7 pin idle", int'(bz), 0);
        count_high(300, hi);
        check("R7 stays idle", hi, 0);

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule